// File: doc/BRIEF.md
# Burst Bit-Clock Synchronizer

This block runs in the master clock domain. From the master clock it makes a bit clock, a one-cycle strobe on each falling edge of that clock, and a one-cycle pulse at the start of each symbol. The symbol period is a programmable number of master cycles. The bit period is that symbol period divided by the number of bits each symbol carries: one, two or four.

Both counters run freely between bursts. Before a burst, the block is armed in one of two ways: a rising edge on the clock-enable input, or a register strobe that is written high and then low. The first rising edge of the external transmit clock after arming restarts both counters a fixed three master cycles later. After the restart the bit clock is in its high phase and the symbol counter is at the start of a symbol. While the enable input is low the bit clock stands still, and the next rising edge of the enable arms the block for the following burst.

The transmit-clock input and a transmit-data bit pass through a two-stage synchronizer. The data bit is captured on each detected rising edge of the transmit clock. It is then latched again on the next falling edge of the bit clock, so that it lines up with the internal timing.

Top module: `burst_bitclk_sync`

## Requirements
- R1: While reset (`rst_n` low) is applied, bit_clk_o is 1 and bit_fall_o, sym_pulse_o and data_o are 0.
- R2: The bit clock is high for the first floor(P/2) cycles of each bit period P and low for the rest. bit_fall_o is high for exactly the first low cycle of each period.
- R3: With clk_en_i held high, sym_pulse_o is high for one master cycle every sym_div_i cycles. sym_div_i is a multiple of 4 from 16 to 16384.
- R4: bits_mode_i selects the bit period P: 0 gives sym_div_i, 1 gives sym_div_i/2, and 2 or 3 give sym_div_i/4. So one symbol holds 1, 2 or 4 bit-clock falls.
- R5: The block is armed either by clk_en_i going from 0 to 1 between two consecutive cycles, or by arm_reg_i going from 1 to 0 between two consecutive cycles.
- R6: If txclk_i is 0 and is sampled 1 at clock edge E while the block is armed, both counters restart at edge E+2. In the cycle after E+2, bit_clk_o is 1 and sym_pulse_o is 1, and counting continues from there.
- R7: Arming is a single flag, and the trigger clears it. A second arm event while armed changes nothing. A rising edge of txclk_i while the block is not armed does not restart the counters.
- R8: While clk_en_i is 0, the counters hold, bit_clk_o keeps its value, and bit_fall_o and sym_pulse_o stay 0 (a trigger still restarts the counters). The next rise of clk_en_i re-arms the block.
- R9: txdata_i is synchronized alongside txclk_i and captured at each detected txclk_i rise. data_o takes the captured bit one cycle after each bit_fall_o and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en_i | input | 1 | Bit-clock enable; its rising edge arms the block |
| txclk_i | input | 1 | External transmit clock, asynchronous to clk |
| txdata_i | input | 1 | Serial data bit that goes with txclk_i |
| arm_reg_i | input | 1 | Register arm strobe; its high-to-low step arms the block |
| sym_div_i | input | DIV_W | Symbol period in master cycles |
| bits_mode_i | input | 2 | Bits per symbol: 0 = 1, 1 = 2, 2 or 3 = 4 |
| bit_clk_o | output | 1 | Bit clock |
| bit_fall_o | output | 1 | One-cycle strobe on each bit-clock falling edge |
| sym_pulse_o | output | 1 | One-cycle symbol-start pulse |
| data_o | output | 1 | Re-latched data bit |

## Verification
The assertions take several things for granted about the inputs. sym_div_i and bits_mode_i must give a bit period of at least four cycles. Both may change only while no burst is being measured. txclk_i must stay at each level long enough for the synchronizer to see every edge. The stimulus programs only legal multiples of four and changes the divider only before re-arming. It holds txclk_i low for several master cycles before each rising edge, so each edge is detected exactly once.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    BITS_ONE  = 2'd0,
    BITS_TWO  = 2'd1,
    BITS_FOUR = 2'd2,
    BITS_FOUR_ALT = 2'd3
  } bits_mode_e;

  function automatic logic [1:0] mode_shift(input logic [1:0] mode);
    case (bits_mode_e'(mode))
      BITS_ONE: mode_shift = 2'd0;
      BITS_TWO: mode_shift = 2'd1;
      default:  mode_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bbs_in_sync.sv
module bbs_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s+1] <= '0;
      else        chain[s+1] <= chain[s];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/bbs_arm.sv
module bbs_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic arm_reg_i,
  input  logic trig_i,
  output logic arm_evt_o,
  output logic armed_o
);
  logic en_q;
  logic reg_q;

  assign arm_evt_o = (en_i & ~en_q) | (reg_q & ~arm_reg_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      reg_q   <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      en_q  <= en_i;
      reg_q <= arm_reg_i;
      if (arm_evt_o)   armed_o <= 1'b1;
      else if (trig_i) armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bbs_counters.sv
module bbs_counters
  import bbs_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] sym_div_i,
  input  logic [1:0]       mode_i,
  output logic             bit_clk_o,
  output logic             sym_pulse_o
);
  logic [DIV_W-1:0] bit_per;
  logic [DIV_W-1:0] half_per;
  logic [DIV_W-1:0] bcnt;
  logic [DIV_W-1:0] scnt;
  logic             bit_wrap;
  logic             sym_wrap;

  assign bit_per  = sym_div_i >> mode_shift(mode_i);
  assign half_per = bit_per >> 1;
  assign bit_wrap = (bcnt >= bit_per - DIV_W'(1));
  assign sym_wrap = (scnt >= sym_div_i - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt        <= '0;
      scnt        <= '0;
      sym_pulse_o <= 1'b0;
    end else if (restart_i) begin
      bcnt        <= '0;
      scnt        <= '0;
      sym_pulse_o <= 1'b1;
    end else if (adv_i) begin
      bcnt        <= bit_wrap ? '0 : bcnt + DIV_W'(1);
      scnt        <= sym_wrap ? '0 : scnt + DIV_W'(1);
      sym_pulse_o <= sym_wrap;
    end else begin
      sym_pulse_o <= 1'b0;
    end
  end

  assign bit_clk_o = (bcnt < half_per);
endmodule

// File: rtl/burst_bitclk_sync.sv
module burst_bitclk_sync #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_i,
  input  logic             txclk_i,
  input  logic             txdata_i,
  input  logic             arm_reg_i,
  input  logic [DIV_W-1:0] sym_div_i,
  input  logic [1:0]       bits_mode_i,
  output logic             bit_clk_o,
  output logic             bit_fall_o,
  output logic             sym_pulse_o,
  output logic             data_o
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              txclk_prev;
  logic              tx_rise;
  logic              trig;
  logic              armed;
  logic              arm_evt;
  logic              bclk_d;
  logic              cap_q;

  bbs_in_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({txdata_i, txclk_i}),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) txclk_prev <= 1'b0;
    else        txclk_prev <= sync_q[0];
  end

  assign tx_rise = sync_q[0] & ~txclk_prev;
  assign trig    = tx_rise & armed;

  bbs_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (clk_en_i),
    .arm_reg_i (arm_reg_i),
    .trig_i    (trig),
    .arm_evt_o (arm_evt),
    .armed_o   (armed)
  );

  bbs_counters #(.DIV_W(DIV_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (clk_en_i),
    .restart_i   (trig),
    .sym_div_i   (sym_div_i),
    .mode_i      (bits_mode_i),
    .bit_clk_o   (bit_clk_o),
    .sym_pulse_o (sym_pulse_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d <= 1'b1;
      cap_q  <= 1'b0;
      data_o <= 1'b0;
    end else begin
      bclk_d <= bit_clk_o;
      if (tx_rise)    cap_q  <= sync_q[1];
      if (bit_fall_o) data_o <= cap_q;
    end
  end

  assign bit_fall_o = bclk_d & ~bit_clk_o;
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker (
  input logic clk,
  input logic rst_n,
  input logic clk_en_i,
  input logic trig,
  input logic arm_evt,
  input logic armed,
  input logic bit_clk_o,
  input logic bit_fall_o,
  input logic sym_pulse_o
);
  AST_SYM_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_pulse_o && !trig |=> !sym_pulse_o);  // R3
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_fall_o |=> !bit_fall_o);  // R2
  AST_RESTART_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> bit_clk_o && sym_pulse_o);  // R6
  AST_TRIG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !arm_evt |=> !armed);  // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i && !trig |=> $stable(bit_clk_o) && !sym_pulse_o);  // R8
endmodule

bind burst_bitclk_sync bbs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en_i    (clk_en_i),
  .trig        (trig),
  .arm_evt     (arm_evt),
  .armed       (armed),
  .bit_clk_o   (bit_clk_o),
  .bit_fall_o  (bit_fall_o),
  .sym_pulse_o (sym_pulse_o)
);

// File: tb/burst_bitclk_sync_bench.sv
module burst_bitclk_sync_bench;
  localparam int DW = 15;
  localparam int NVEC = 5;
  // columns: symbol divide, bits mode, expected bit period
  localparam int VEC [NVEC][3] = '{
    '{16, 0, 16}, '{48, 1, 24}, '{64, 2, 16}, '{20, 2, 5}, '{16, 3, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic txclk = 1'b0;
  logic txdata = 1'b0;
  logic arm_reg = 1'b0;
  logic [DW-1:0] sym_div = DW'(16);
  logic [1:0] mode = 2'd0;
  logic bit_clk, bit_fall, sym_pulse, data_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic last_d = 1'b0;

  always #2 clk = ~clk;

  burst_bitclk_sync #(.DIV_W(DW)) u_burst_bitclk_sync (
    .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en), .txclk_i(txclk),
    .txdata_i(txdata), .arm_reg_i(arm_reg), .sym_div_i(sym_div),
    .bits_mode_i(mode), .bit_clk_o(bit_clk), .bit_fall_o(bit_fall),
    .sym_pulse_o(sym_pulse), .data_o(data_q)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Arm, raise txclk, check restart, then measure one full symbol.
  task automatic burst(input int div, input int md, input int bper,
                       input bit use_reg, input logic dbit);
    int half, hi, fall_at, falls, sym_at;
    sym_div = DW'(div);
    mode = md[1:0];
    txclk = 1'b0;
    step(3);
    if (use_reg) begin
      arm_reg = 1'b1; step(); arm_reg = 1'b0; step();
    end else begin
      clk_en = 1'b0; step(); clk_en = 1'b1; step();
    end
    txclk = 1'b1;
    txdata = dbit;
    step(3);
    chk("R6 bit clock high after restart", int'(bit_clk), 1);
    chk("R6 symbol pulse at restart", int'(sym_pulse), 1);
    half = bper / 2;
    hi = 1; fall_at = -1; falls = 0; sym_at = -1;
    for (int c = 1; c <= div; c++) begin
      step();
      if (c < bper && bit_clk) hi++;
      if (bit_fall) begin
        falls++;
        if (fall_at < 0) fall_at = c;
      end
      if (sym_pulse && sym_at < 0) sym_at = c;
      if (c == half) chk("R9 data held before relatch", int'(data_q), int'(last_d));
      if (c == half + 1) chk("R9 data relatched after fall", int'(data_q), int'(dbit));
    end
    last_d = dbit;
    chk("R2 high phase length", hi, half);
    chk("R2 first fall strobe cycle", fall_at, half);
    chk("R4 falls per symbol", falls, div / bper);
    chk("R3 symbol period", sym_at, div);
  endtask

  initial begin
    int viol, first_sym;
    step(2);
    chk("R1 reset bit_clk", int'(bit_clk), 1);
    chk("R1 reset bit_fall", int'(bit_fall), 0);
    chk("R1 reset sym_pulse", int'(sym_pulse), 0);
    chk("R1 reset data", int'(data_q), 0);
    rst_n = 1'b1;
    clk_en = 1'b1;
    step(4);

    for (int v = 0; v < NVEC; v++)
      burst(VEC[v][0], VEC[v][1], VEC[v][2], (v % 2) == 1, logic'((v % 2) == 0));

    // R7: unarmed txclk rise does not restart (period 16, half 8)
    burst(16, 0, 16, 1'b0, 1'b1);
    step(); txclk = 1'b0; step(2); txclk = 1'b1; step(3);
    chk("R7 unarmed rise ignored", int'(sym_pulse), 0);
    first_sym = -1;
    for (int c = 7; c <= 16; c++) begin
      step();
      if (sym_pulse && first_sym < 0) first_sym = c;
    end
    chk("R7 symbol timing kept", first_sym, 16);

    // R7: second arm event while armed; one trigger only
    txclk = 1'b0; step(3);
    clk_en = 1'b0; step(); clk_en = 1'b1; step();
    arm_reg = 1'b1; step(); arm_reg = 1'b0; step();
    txclk = 1'b1; step(3);
    chk("R5 armed restart", int'(sym_pulse), 1);
    step(); txclk = 1'b0; step(2); txclk = 1'b1; step(3);
    chk("R7 double arm gives one trigger", int'(sym_pulse), 0);

    // R8: enable low freezes outputs (now at cycle 6, high phase)
    clk_en = 1'b0;
    viol = 0;
    for (int c = 0; c < 6; c++) begin
      step();
      if (!bit_clk || sym_pulse || bit_fall) viol++;
    end
    chk("R8 outputs frozen while disabled", viol, 0);
    txclk = 1'b0;
    clk_en = 1'b1; step(3);
    txclk = 1'b1; step(3);
    chk("R8 enable rise re-arms", int'(sym_pulse), 1);
    chk("R8 restart bit clock high", int'(bit_clk), 1);

    // R1: reset mid-run
    step(9);
    rst_n = 1'b0;
    step();
    chk("R1 mid-run reset bit_clk", int'(bit_clk), 1);
    chk("R1 mid-run reset data", int'(data_q), 0);
    chk("R1 mid-run reset sym_pulse", int'(sym_pulse), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule